// File: doc/BRIEF.md
# Software Write-Protection Command Sequencer

This block sits in the write path of a byte-wide non-volatile memory and rules on every byte write before it reaches the page buffer. It keeps one protection flag. While the flag is clear, ordinary writes go through. While it is set, a write only takes effect when a three-byte key prefix opens the current write period. A write with no prefix while protected stores nothing, but it still makes the busy timer run a full programming cycle, so software sees the same busy period either way.

The three-byte key prefix also arms protection, and protection takes effect when the write period ends. A longer six-byte key sequence arms the clearing of protection in the same way. Key bytes that complete a step of a sequence are consumed and are never passed on as data. A byte that breaks a sequence part-way sends the matcher back to its start, and that byte is then judged afresh as a possible first key byte. The flag has its own factory-clear reset. The functional reset returns the matcher and the period state to idle but leaves the flag as it is, as a non-volatile bit would be.

The end of each write period comes from the external programming timer as a one-cycle pulse. The block returns two registered verdict pulses, one cycle after each write strobe: pass to the page buffer, or run a dummy busy cycle.

Top module: `wrprot_seq`

## Requirements
- R1: After factory clear and functional reset, `prot_on`, `wr_pass` and `dummy_busy` are 0. A write while unprotected raises `wr_pass` (and not `dummy_busy`) in the cycle after the strobe.
- R2: The arm sequence is data 0xAA at address 0x05555, then 0x55 at 0x02AAA, then 0xA0 at 0x05555. Each of these bytes gives neither `wr_pass` nor `dummy_busy`.
- R3: After an arm or clear sequence, data writes raise `wr_pass` until the next `period_done` pulse, even while protected. After that pulse, the window is closed.
- R4: While protected and with no open window, a write that is not a key byte raises `dummy_busy` and not `wr_pass`.
- R5: The clear sequence is 0xAA@0x05555, 0x55@0x02AAA, 0x80@0x05555, 0xAA@0x05555, 0x55@0x02AAA, 0x20@0x05555, all consumed. Protection drops at the next `period_done`, and later plain writes pass.
- R6: A byte that breaks a sequence returns the matcher to idle and is judged as a fresh byte. If it is 0xAA@0x05555 it starts a new sequence. Otherwise it is handled as data.
- R7: Pulsing `rst_n` does not change `prot_on`. It discards a partly matched sequence and any open window.
- R8: When several sequences complete in one write period, the last one decides the flag at `period_done`.
- R9: `prot_on` changes only in the cycle after a `period_done` pulse. Without an arm sequence it keeps its value across periods.
- R10: `wr_pass` and `dummy_busy` are never high together, and each is a registered response one cycle after `wr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Functional reset, active low, asynchronous assert |
| fclr_n | input | 1 | Factory clear of the protection flag, active low |
| wr_valid | input | 1 | One-cycle strobe per byte write |
| wr_addr | input | 17 | Byte address of the write |
| wr_data | input | 8 | Byte value of the write |
| period_done | input | 1 | One-cycle pulse at the end of a write period |
| wr_pass | output | 1 | Byte may enter the page buffer |
| dummy_busy | output | 1 | Byte dropped; run the busy timer without storing |
| prot_on | output | 1 | Current protection flag |

## Verification
The hardest state to reach from the ports is a matcher caught part-way through a sequence when something interrupts it: a breaking byte that is itself a first key byte, or a functional reset between two key bytes. The bench feeds a repeated 0xAA@0x05555 in the middle of a prefix and checks that the sequence still completes from the second copy. It also resets between the second and third key bytes and shows that the third byte then counts as a dropped data write. Several sequences in one period, in both orders, check that the last one wins.

// File: rtl/wpseq_pkg.sv
package wpseq_pkg;

  // Matcher position within the key sequences
  typedef enum logic [2:0] {
    M_IDLE = 3'd0,  // nothing matched
    M_K1   = 3'd1,  // first key byte seen
    M_K2   = 3'd2,  // second key byte seen
    M_D3   = 3'd3,  // clear-sequence third byte seen
    M_D4   = 3'd4,  // clear-sequence fourth byte seen
    M_D5   = 3'd5   // clear-sequence fifth byte seen
  } mstate_e;

endpackage

// File: rtl/wpseq_matcher.sv
module wpseq_matcher
  import wpseq_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8,
  parameter logic [AW-1:0] ADR_P = 17'h05555,
  parameter logic [AW-1:0] ADR_Q = 17'h02AAA,
  parameter logic [DW-1:0] KEY_A = 8'hAA,
  parameter logic [DW-1:0] KEY_B = 8'h55,
  parameter logic [DW-1:0] KEY_ON = 8'hA0,
  parameter logic [DW-1:0] KEY_PRE = 8'h80,
  parameter logic [DW-1:0] KEY_OFF = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          hit_on,
  output logic          hit_off,
  output logic          swallow
);

  mstate_e st_q, st_nx;
  logic    step_ok;
  logic    is_a, is_b, is_on, is_pre, is_off;

  always_comb begin
    is_a   = (wr_addr == ADR_P) && (wr_data == KEY_A);
    is_b   = (wr_addr == ADR_Q) && (wr_data == KEY_B);
    is_on  = (wr_addr == ADR_P) && (wr_data == KEY_ON);
    is_pre = (wr_addr == ADR_P) && (wr_data == KEY_PRE);
    is_off = (wr_addr == ADR_P) && (wr_data == KEY_OFF);
  end

  // Next state: advance on the expected byte, else restart with this byte
  always_comb begin
    st_nx   = st_q;
    hit_on  = 1'b0;
    hit_off = 1'b0;
    swallow = 1'b0;
    step_ok = 1'b0;
    if (wr_valid) begin
      unique case (st_q)
        M_K1: if (is_b) begin
          st_nx = M_K2; step_ok = 1'b1;
        end
        M_K2: begin
          if (is_on) begin
            st_nx = M_IDLE; hit_on = 1'b1; step_ok = 1'b1;
          end else if (is_pre) begin
            st_nx = M_D3; step_ok = 1'b1;
          end
        end
        M_D3: if (is_a) begin
          st_nx = M_D4; step_ok = 1'b1;
        end
        M_D4: if (is_b) begin
          st_nx = M_D5; step_ok = 1'b1;
        end
        M_D5: if (is_off) begin
          st_nx = M_IDLE; hit_off = 1'b1; step_ok = 1'b1;
        end
        default: ;
      endcase
      if (step_ok) begin
        swallow = 1'b1;
      end else if (is_a) begin
        st_nx   = M_K1;
        swallow = 1'b1;
      end else begin
        st_nx   = M_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= M_IDLE;
    end else if (wr_valid) begin
      st_q <= st_nx;
    end
  end

  // R6: a byte that is not consumed leaves the matcher idle
  p_break_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !swallow) |=> (st_q == M_IDLE));

  // R2: completing the arm sequence returns the matcher to idle
  p_arm_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_on |=> (st_q == M_IDLE));

endmodule

// File: rtl/wpseq_guard.sv
module wpseq_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic fclr_n,
  input  logic period_done,
  input  logic hit_on,
  input  logic hit_off,
  output logic prot_q,
  output logic win_q
);

  logic pend_v_q, pend_val_q;
  logic pend_v_nx, pend_val_nx, win_nx;
  logic hit_any, prot_ld;

  always_comb begin
    hit_any     = hit_on || hit_off;
    pend_v_nx   = hit_any ? 1'b1 : (period_done ? 1'b0 : pend_v_q);
    pend_val_nx = hit_on ? 1'b1 : (hit_off ? 1'b0 : pend_val_q);
    win_nx      = hit_any ? 1'b1 : (period_done ? 1'b0 : win_q);
    prot_ld     = period_done && pend_v_q;
  end

  // Protection flag: only the factory clear resets it
  always_ff @(posedge clk or negedge fclr_n) begin
    if (!fclr_n) begin
      prot_q <= 1'b0;
    end else if (prot_ld) begin
      prot_q <= pend_val_q;
    end
  end

  // Per-period state: cleared by the functional reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q   <= 1'b0;
      pend_val_q <= 1'b0;
      win_q      <= 1'b0;
    end else begin
      pend_v_q   <= pend_v_nx;
      pend_val_q <= pend_val_nx;
      win_q      <= win_nx;
    end
  end

  // R9: the flag holds unless a period has just ended
  p_prot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || !fclr_n)
    !period_done |=> $stable(prot_q));

  // R8: the latest completed sequence owns the pending value
  p_last_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_off |=> (pend_v_q && !pend_val_q));

  // R3: the window closes at a period end with no new sequence
  p_win_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (period_done && !hit_on && !hit_off) |=> !win_q);

endmodule

// File: rtl/wrprot_seq.sv
module wrprot_seq #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fclr_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          period_done,
  output logic          wr_pass,
  output logic          dummy_busy,
  output logic          prot_on
);

  logic hit_on, hit_off, swallow;
  logic prot_q, win_q;
  logic allow, pass_nx, dummy_nx;

  wpseq_matcher #(.AW(AW), .DW(DW)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .hit_on   (hit_on),
    .hit_off  (hit_off),
    .swallow  (swallow)
  );

  wpseq_guard u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .fclr_n      (fclr_n),
    .period_done (period_done),
    .hit_on      (hit_on),
    .hit_off     (hit_off),
    .prot_q      (prot_q),
    .win_q       (win_q)
  );

  always_comb begin
    allow    = !prot_q || win_q;
    pass_nx  = wr_valid && !swallow && allow;
    dummy_nx = wr_valid && !swallow && !allow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pass    <= 1'b0;
      dummy_busy <= 1'b0;
    end else begin
      wr_pass    <= pass_nx;
      dummy_busy <= dummy_nx;
    end
  end

  assign prot_on = prot_q;

  // R10: at most one verdict per write
  p_one_verdict_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_pass && dummy_busy));

  // R2: a consumed key byte produces no verdict
  p_key_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && swallow) |=> (!wr_pass && !dummy_busy));

  // R4: a protected write outside a window is dropped with busy
  p_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n || !fclr_n)
    (wr_valid && !swallow && prot_q && !win_q) |=> (dummy_busy && !wr_pass));

  // R10: no verdict appears without a write strobe
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> (!wr_pass && !dummy_busy));

endmodule

// File: tb/wrprot_seq_test.sv
`timescale 1ns/1ps
module wrprot_seq_test;

  logic        clk = 1'b0;
  logic        rst_n, fclr_n, wr_valid, period_done;
  logic [16:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wr_pass, dummy_busy, prot_on;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  wrprot_seq uut (
    .clk(clk), .rst_n(rst_n), .fclr_n(fclr_n), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .period_done(period_done),
    .wr_pass(wr_pass), .dummy_busy(dummy_busy), .prot_on(prot_on)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d,
                    input logic ep, input logic ed, input string tag);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    chk({tag, " pass"}, wr_pass, ep);
    chk({tag, " dummy"}, dummy_busy, ed);
  endtask

  task automatic period_end();
    @(negedge clk); period_done = 1'b1;
    @(negedge clk); period_done = 1'b0;
  endtask

  task automatic seq_on(input string tag);
    wr(17'h05555, 8'hAA, 1'b0, 1'b0, tag);
    wr(17'h02AAA, 8'h55, 1'b0, 1'b0, tag);
    wr(17'h05555, 8'hA0, 1'b0, 1'b0, tag);
  endtask

  task automatic seq_off(input string tag);
    wr(17'h05555, 8'hAA, 1'b0, 1'b0, tag);
    wr(17'h02AAA, 8'h55, 1'b0, 1'b0, tag);
    wr(17'h05555, 8'h80, 1'b0, 1'b0, tag);
    wr(17'h05555, 8'hAA, 1'b0, 1'b0, tag);
    wr(17'h02AAA, 8'h55, 1'b0, 1'b0, tag);
    wr(17'h05555, 8'h20, 1'b0, 1'b0, tag);
  endtask

  task automatic t_reset_state();
    chk("R1 prot after clear", prot_on, 1'b0);
    chk("R1 pass idle", wr_pass, 1'b0);
    chk("R1 dummy idle", dummy_busy, 1'b0);
    wr(17'h00100, 8'h12, 1'b1, 1'b0, "R1 open write");
  endtask

  task automatic t_arm();
    seq_on("R2 arm key");
    chk("R9 prot before period end", prot_on, 1'b0);
    wr(17'h00101, 8'h34, 1'b1, 1'b0, "R3 window data");
    period_end();
    chk("R2 prot after period end", prot_on, 1'b1);
  endtask

  task automatic t_blocked();
    wr(17'h00102, 8'h56, 1'b0, 1'b1, "R4 blocked write");
    period_end();
    chk("R9 prot kept", prot_on, 1'b1);
  endtask

  task automatic t_window_protected();
    seq_on("R3 unlock key");
    wr(17'h00200, 8'h01, 1'b1, 1'b0, "R3 first data");
    wr(17'h00201, 8'h02, 1'b1, 1'b0, "R3 second data");
    period_end();
    wr(17'h00202, 8'h03, 1'b0, 1'b1, "R3 window closed");
  endtask

  task automatic t_break();
    wr(17'h05555, 8'hAA, 1'b0, 1'b0, "R6 first key");
    wr(17'h00010, 8'h33, 1'b0, 1'b1, "R6 break byte as data");
    wr(17'h05555, 8'hAA, 1'b0, 1'b0, "R6 key a");
    wr(17'h05555, 8'hAA, 1'b0, 1'b0, "R6 repeated key restarts");
    wr(17'h02AAA, 8'h55, 1'b0, 1'b0, "R6 key b");
    wr(17'h05555, 8'hA0, 1'b0, 1'b0, "R6 key on");
    wr(17'h00040, 8'h5A, 1'b1, 1'b0, "R6 data after restart");
    period_end();
    chk("R6 prot stays", prot_on, 1'b1);
  endtask

  task automatic t_func_reset();
    wr(17'h05555, 8'hAA, 1'b0, 1'b0, "R7 key a");
    wr(17'h02AAA, 8'h55, 1'b0, 1'b0, "R7 key b");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R7 prot survives reset", prot_on, 1'b1);
    wr(17'h05555, 8'hA0, 1'b0, 1'b1, "R7 orphan key dropped");
  endtask

  task automatic t_disarm();
    seq_off("R5 clear key");
    chk("R9 prot before clear period end", prot_on, 1'b1);
    wr(17'h00100, 8'h77, 1'b1, 1'b0, "R5 window data");
    period_end();
    chk("R5 prot cleared", prot_on, 1'b0);
    wr(17'h00200, 8'h88, 1'b1, 1'b0, "R5 open write");
    wr(17'h05555, 8'hAA, 1'b0, 1'b0, "R6 open key a");
    wr(17'h00020, 8'h44, 1'b1, 1'b0, "R6 open break passes");
  endtask

  task automatic t_last_wins();
    seq_on("R8 on then");
    seq_off("R8 off");
    period_end();
    chk("R8 off last", prot_on, 1'b0);
    seq_off("R8 off then");
    seq_on("R8 on");
    period_end();
    chk("R8 on last", prot_on, 1'b1);
    seq_off("R8 restore");
    period_end();
    chk("R8 restored", prot_on, 1'b0);
    period_end();
    chk("R9 idle period keeps", prot_on, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fclr_n = 1'b0; wr_valid = 1'b0; period_done = 1'b0;
    wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; fclr_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_arm();
    t_blocked();
    t_window_protected();
    t_break();
    t_func_reset();
    t_disarm();
    t_last_wins();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule